// File: doc/BRIEF.md
# Serial Port Control and Loopback Layer

This block is the control shell placed around a serial transmitter/receiver pair. It holds one control word that software writes and reads back. From that word it derives the run state of the transmit and receive sections, qualifies each transmit start against the clear-to-send input, drives four active-low modem handshake pins, and steers the serial and modem lines through the loopback and infrared-mode multiplexers.

The shifters, FIFOs, baud generator and infrared encoder/decoder sit outside. They reach the block only through a few handshake ports: the busy flags of the two sections, a transmit request, the receive FIFO fill level, and the serial core-side lines. A section's run state follows its enables only while that section reports idle, so a character already on the line always completes.

Top module: `uart_ctl_loop`

## Requirements
- R1: After reset the control word reads 0. All four modem outputs (`dtr_n_o`, `rts_n_o`, `out1_n_o`, `out2_n_o`) are 1. `tx_run_o`, `rx_run_o` and `tx_start_o` are 0.
- R2: A write with `reg_we` high loads `reg_wdata` into the control word, and `reg_rdata` returns it. The bit layout is: 0 master enable, 1 transmit enable, 2 receive enable, 3 loopback, 4 infrared mode, 5 DTR, 6 RTS, 7 OUT1, 8 OUT2, 9 RTS flow control, 10 CTS flow control.
- R3: `dtr_n_o`, `out1_n_o` and `out2_n_o` are the inverse of control bits 5, 7 and 8. While bit 9 is 0, `rts_n_o` is the inverse of bit 6.
- R4: While bit 9 is 1, `rts_n_o` is 0 when `rx_level_i` is below `RX_DEPTH` and 1 when it is not. Bit 6 is ignored.
- R5: While bit 10 is 1, `tx_start_o` can be 1 only when the clear-to-send line is low, after that line has passed `CTS_SYNC` flip-flops. While bit 10 is 0, the line has no effect.
- R6: `tx_start_o` is 1 only when `tx_run_o` is 1, `tx_req_i` is 1 and `tx_busy_i` is 0.
- R7: `tx_run_o` loads (bit0 AND bit1) and `rx_run_o` loads (bit0 AND bit2). Each loads only at a clock edge where its own busy input is 0; otherwise it holds.
- R8: With bit 3 set, `ir_test_i` low and infrared mode inactive, `rxd_core_o` follows `txd_core_i` and `rxd_i` is ignored.
- R9: With bits 3 and 4 set and `ir_test_i` high, `ir_in_core_o` is the inverse of `ir_out_core_i`.
- R10: With bit 3 set, the core-side modem inputs are taken from the block's own outputs, not the pins: CTS from RTS, DSR from DTR, DCD from OUT1, RI from OUT2.
- R11: Infrared mode is active when bits 0 and 4 are both 1. While it is active, `txd_o` is 1 and `rxd_core_o` is 1. While it is inactive, `ir_out_n_o` is 0 and `ir_in_core_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 11 | Control word write data |
| reg_rdata | output | 11 | Control word read-back |
| ir_test_i | input | 1 | Infrared test select for loopback |
| tx_busy_i | input | 1 | Transmit shifter is mid-character |
| tx_req_i | input | 1 | Transmitter has a character waiting |
| tx_start_o | output | 1 | Permission to start a character |
| tx_run_o | output | 1 | Transmit section running |
| rx_busy_i | input | 1 | Receive shifter is mid-character |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_run_o | output | 1 | Receive section running |
| txd_core_i | input | 1 | Serial data from the transmitter |
| txd_o | output | 1 | Serial data pin |
| rxd_i | input | 1 | Serial data input pin |
| rxd_core_o | output | 1 | Serial data to the receiver |
| ir_out_core_i | input | 1 | Active-low pulse from the infrared encoder |
| ir_out_n_o | output | 1 | Infrared output pin, active low |
| ir_in_i | input | 1 | Infrared input pin |
| ir_in_core_o | output | 1 | Infrared data to the decoder |
| cts_n_i | input | 1 | Clear-to-send pin |
| dsr_n_i | input | 1 | Data-set-ready pin |
| dcd_n_i | input | 1 | Carrier-detect pin |
| ri_n_i | input | 1 | Ring-indicator pin |
| cts_n_core_o | output | 1 | Clear-to-send after loopback selection |
| dsr_n_core_o | output | 1 | Data-set-ready after loopback selection |
| dcd_n_core_o | output | 1 | Carrier-detect after loopback selection |
| ri_n_core_o | output | 1 | Ring-indicator after loopback selection |
| dtr_n_o | output | 1 | Data-terminal-ready pin |
| rts_n_o | output | 1 | Request-to-send pin |
| out1_n_o | output | 1 | General modem output 1 |
| out2_n_o | output | 1 | General modem output 2 |

## Verification
A control-word write that changes an enable can land in the same cycle as the busy flag of a section. The bench provokes this by raising the busy flag before it writes the control word, in both directions: enabling and disabling. It judges the result by checking that the run output keeps its old value for several cycles. It then checks that the run output takes the new value within two cycles after busy falls. A second overlap comes from the transmit request being high while the synchronized clear-to-send changes. The bench checks that the start permission stays low until the synchronizer latency has passed.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;
   localparam int CTRL_W = 11;
   localparam int B_MASTER = 0;
   localparam int B_TXEN   = 1;
   localparam int B_RXEN   = 2;
   localparam int B_LOOP   = 3;
   localparam int B_IR     = 4;
   localparam int B_DTR    = 5;
   localparam int B_RTS    = 6;
   localparam int B_OUT1   = 7;
   localparam int B_OUT2   = 8;
   localparam int B_RTSF   = 9;
   localparam int B_CTSF   = 10;
   localparam int N_SEC    = 2;
   localparam int SEC_TX   = 0;
   localparam int SEC_RX   = 1;
endpackage

// File: rtl/uart_ctl_regs.sv
module uart_ctl_regs
   import uart_ctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CTRL_W-1:0] wdata,
   output logic [CTRL_W-1:0] ctrl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl <= '0;
      else if (we) ctrl <= wdata;
   end
endmodule

// File: rtl/uart_ctl_gate.sv
module uart_ctl_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_i,
   input  logic want_i,
   output logic run_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_o <= 1'b0;
      else if (!busy_i) run_o <= want_i;
   end
endmodule

// File: rtl/uart_ctl_route.sv
module uart_ctl_route
   import uart_ctl_pkg::*;
(
   input  logic [CTRL_W-1:0] ctrl,
   input  logic              ir_test_i,
   input  logic              room_i,
   input  logic              txd_core_i,
   output logic              txd_o,
   input  logic              rxd_i,
   output logic              rxd_core_o,
   input  logic              ir_out_core_i,
   output logic              ir_out_n_o,
   input  logic              ir_in_i,
   output logic              ir_in_core_o,
   input  logic              cts_n_i,
   input  logic              dsr_n_i,
   input  logic              dcd_n_i,
   input  logic              ri_n_i,
   output logic              cts_n_core_o,
   output logic              dsr_n_core_o,
   output logic              dcd_n_core_o,
   output logic              ri_n_core_o,
   output logic              dtr_n_o,
   output logic              rts_n_o,
   output logic              out1_n_o,
   output logic              out2_n_o
);
   logic ir_on, loop_ser, loop_ir;

   always_comb begin
      ir_on    = ctrl[B_MASTER] & ctrl[B_IR];
      loop_ser = ctrl[B_LOOP] & ~ir_test_i;
      loop_ir  = ctrl[B_LOOP] & ctrl[B_IR] & ir_test_i;

      dtr_n_o  = ~ctrl[B_DTR];
      out1_n_o = ~ctrl[B_OUT1];
      out2_n_o = ~ctrl[B_OUT2];
      rts_n_o  = ctrl[B_RTSF] ? ~room_i : ~ctrl[B_RTS];

      txd_o      = ir_on ? 1'b1 : txd_core_i;
      rxd_core_o = ir_on ? 1'b1 : (loop_ser ? txd_core_i : rxd_i);
      ir_out_n_o = ir_on ? ir_out_core_i : 1'b0;
      if (loop_ir)    ir_in_core_o = ~ir_out_core_i;
      else if (ir_on) ir_in_core_o = ir_in_i;
      else            ir_in_core_o = 1'b0;

      cts_n_core_o = ctrl[B_LOOP] ? rts_n_o  : cts_n_i;
      dsr_n_core_o = ctrl[B_LOOP] ? dtr_n_o  : dsr_n_i;
      dcd_n_core_o = ctrl[B_LOOP] ? out1_n_o : dcd_n_i;
      ri_n_core_o  = ctrl[B_LOOP] ? out2_n_o : ri_n_i;
   end
endmodule

// File: rtl/uart_ctl_loop.sv
module uart_ctl_loop
   import uart_ctl_pkg::*;
#(
   parameter  int RX_DEPTH = 32,
   parameter  int CTS_SYNC = 2,
   localparam int LVL_W    = $clog2(RX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [CTRL_W-1:0] reg_wdata,
   output logic [CTRL_W-1:0] reg_rdata,
   input  logic              ir_test_i,
   input  logic              tx_busy_i,
   input  logic              tx_req_i,
   output logic              tx_start_o,
   output logic              tx_run_o,
   input  logic              rx_busy_i,
   input  logic [LVL_W-1:0]  rx_level_i,
   output logic              rx_run_o,
   input  logic              txd_core_i,
   output logic              txd_o,
   input  logic              rxd_i,
   output logic              rxd_core_o,
   input  logic              ir_out_core_i,
   output logic              ir_out_n_o,
   input  logic              ir_in_i,
   output logic              ir_in_core_o,
   input  logic              cts_n_i,
   input  logic              dsr_n_i,
   input  logic              dcd_n_i,
   input  logic              ri_n_i,
   output logic              cts_n_core_o,
   output logic              dsr_n_core_o,
   output logic              dcd_n_core_o,
   output logic              ri_n_core_o,
   output logic              dtr_n_o,
   output logic              rts_n_o,
   output logic              out1_n_o,
   output logic              out2_n_o
);
   if (RX_DEPTH < 1) begin : g_bad_depth
      $error("RX_DEPTH must be at least 1");
   end
   if (CTS_SYNC < 0 || CTS_SYNC > 4) begin : g_bad_sync
      $error("CTS_SYNC must be in 0..4");
   end

   logic [CTRL_W-1:0] ctrl;
   logic [N_SEC-1:0]  sec_busy, sec_want, sec_run;
   logic              room, cts_n_s;

   uart_ctl_regs u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata), .ctrl(ctrl)
   );

   assign sec_busy[SEC_TX] = tx_busy_i;
   assign sec_busy[SEC_RX] = rx_busy_i;
   assign sec_want[SEC_TX] = ctrl[B_MASTER] & ctrl[B_TXEN];
   assign sec_want[SEC_RX] = ctrl[B_MASTER] & ctrl[B_RXEN];

   for (genvar s = 0; s < N_SEC; s++) begin : g_sec
      uart_ctl_gate u_gate (
         .clk(clk), .rst_n(rst_n), .busy_i(sec_busy[s]),
         .want_i(sec_want[s]), .run_o(sec_run[s])
      );
   end

   assign room = rx_level_i < LVL_W'(RX_DEPTH);

   uart_ctl_route u_route (
      .ctrl(ctrl), .ir_test_i(ir_test_i), .room_i(room),
      .txd_core_i(txd_core_i), .txd_o(txd_o), .rxd_i(rxd_i), .rxd_core_o(rxd_core_o),
      .ir_out_core_i(ir_out_core_i), .ir_out_n_o(ir_out_n_o),
      .ir_in_i(ir_in_i), .ir_in_core_o(ir_in_core_o),
      .cts_n_i(cts_n_i), .dsr_n_i(dsr_n_i), .dcd_n_i(dcd_n_i), .ri_n_i(ri_n_i),
      .cts_n_core_o(cts_n_core_o), .dsr_n_core_o(dsr_n_core_o),
      .dcd_n_core_o(dcd_n_core_o), .ri_n_core_o(ri_n_core_o),
      .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o), .out1_n_o(out1_n_o), .out2_n_o(out2_n_o)
   );

   if (CTS_SYNC == 0) begin : g_cts_direct
      assign cts_n_s = cts_n_core_o;
   end else begin : g_cts_sync
      logic [CTS_SYNC-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '1;
         else        sh <= {sh[CTS_SYNC-2+1-1:0], cts_n_core_o} >> 0;
      end
      assign cts_n_s = sh[CTS_SYNC-1];
   end

   assign reg_rdata  = ctrl;
   assign tx_run_o   = sec_run[SEC_TX];
   assign rx_run_o   = sec_run[SEC_RX];
   assign tx_start_o = tx_run_o & tx_req_i & ~tx_busy_i & (~ctrl[B_CTSF] | ~cts_n_s);
endmodule

// File: rtl/uart_ctl_chk.sv
module uart_ctl_chk
   import uart_ctl_pkg::*;
#(
   parameter int RX_DEPTH = 32,
   parameter int LVL_W    = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CTRL_W-1:0] reg_rdata,
   input logic              tx_busy_i,
   input logic              rx_busy_i,
   input logic              tx_req_i,
   input logic              tx_start_o,
   input logic              tx_run_o,
   input logic              rx_run_o,
   input logic [LVL_W-1:0]  rx_level_i,
   input logic              rts_n_o,
   input logic              dtr_n_o,
   input logic              txd_o,
   input logic              cts_n_core_o,
   input logic              dsr_n_core_o
);
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy_i |=> $stable(tx_run_o)); // R7
   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_busy_i |=> $stable(rx_run_o)); // R7
   AST_START_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start_o |-> (tx_run_o && tx_req_i && !tx_busy_i)); // R6
   AST_RTS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[B_RTSF] && int'(rx_level_i) >= RX_DEPTH) |-> rts_n_o); // R4
   AST_DTR_INV: assert property (@(posedge clk) disable iff (!rst_n)
      dtr_n_o != reg_rdata[B_DTR]); // R3
   AST_LOOP_MODEM: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[B_LOOP] |-> (cts_n_core_o == rts_n_o && dsr_n_core_o == dtr_n_o)); // R10
   AST_IR_TXD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[B_MASTER] && reg_rdata[B_IR]) |-> txd_o); // R11
endmodule

bind uart_ctl_loop uart_ctl_chk #(.RX_DEPTH(RX_DEPTH), .LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .tx_busy_i(tx_busy_i),
   .rx_busy_i(rx_busy_i), .tx_req_i(tx_req_i), .tx_start_o(tx_start_o),
   .tx_run_o(tx_run_o), .rx_run_o(rx_run_o), .rx_level_i(rx_level_i),
   .rts_n_o(rts_n_o), .dtr_n_o(dtr_n_o), .txd_o(txd_o),
   .cts_n_core_o(cts_n_core_o), .dsr_n_core_o(dsr_n_core_o)
);

// File: tb/uart_ctl_loop_bench.sv
`timescale 1ns/1ps
module uart_ctl_loop_bench;
   localparam int DEPTH = 32;
   localparam int LW    = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [10:0] reg_wdata = '0;
   logic [10:0] reg_rdata;
   logic ir_test_i = 1'b0, tx_busy_i = 1'b0, tx_req_i = 1'b0, rx_busy_i = 1'b0;
   logic [LW-1:0] rx_level_i = '0;
   logic txd_core_i = 1'b1, rxd_i = 1'b1, ir_out_core_i = 1'b0, ir_in_i = 1'b0;
   logic cts_n_i = 1'b1, dsr_n_i = 1'b1, dcd_n_i = 1'b1, ri_n_i = 1'b1;
   logic tx_start_o, tx_run_o, rx_run_o, txd_o, rxd_core_o, ir_out_n_o, ir_in_core_o;
   logic cts_n_core_o, dsr_n_core_o, dcd_n_core_o, ri_n_core_o;
   logic dtr_n_o, rts_n_o, out1_n_o, out2_n_o;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   uart_ctl_loop #(.RX_DEPTH(DEPTH), .CTS_SYNC(2)) u_uart_ctl_loop (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ir_test_i(ir_test_i), .tx_busy_i(tx_busy_i), .tx_req_i(tx_req_i),
      .tx_start_o(tx_start_o), .tx_run_o(tx_run_o), .rx_busy_i(rx_busy_i),
      .rx_level_i(rx_level_i), .rx_run_o(rx_run_o), .txd_core_i(txd_core_i), .txd_o(txd_o),
      .rxd_i(rxd_i), .rxd_core_o(rxd_core_o), .ir_out_core_i(ir_out_core_i),
      .ir_out_n_o(ir_out_n_o), .ir_in_i(ir_in_i), .ir_in_core_o(ir_in_core_o),
      .cts_n_i(cts_n_i), .dsr_n_i(dsr_n_i), .dcd_n_i(dcd_n_i), .ri_n_i(ri_n_i),
      .cts_n_core_o(cts_n_core_o), .dsr_n_core_o(dsr_n_core_o),
      .dcd_n_core_o(dcd_n_core_o), .ri_n_core_o(ri_n_core_o),
      .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o), .out1_n_o(out1_n_o), .out2_n_o(out2_n_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [10:0] v);
      @(negedge clk);
      reg_we = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
      tick(1);
   endtask

   task automatic t_reset;
      check("R1 ctrl", 32'(reg_rdata), 0);
      check("R1 modem outs", {dtr_n_o, rts_n_o, out1_n_o, out2_n_o}, 4'hF);
      check("R1 run/start", {tx_run_o, rx_run_o, tx_start_o}, 0);
   endtask

   task automatic t_regs;
      wr(11'h5A4);
      check("R2 readback", 32'(reg_rdata), 32'h5A4);
      wr(11'h0E0);
      check("R2 readback2", 32'(reg_rdata), 32'h0E0);
      check("R3 dtr/rts/out1/out2", {dtr_n_o, rts_n_o, out1_n_o, out2_n_o}, 4'b0001);
      wr(11'h100);
      check("R3 out2 only", {dtr_n_o, rts_n_o, out1_n_o, out2_n_o}, 4'b1110);
   endtask

   task automatic t_rts;
      wr(11'h200);
      rx_level_i = '0; tick(1);
      check("R4 empty", rts_n_o, 0);
      rx_level_i = LW'(DEPTH); tick(1);
      check("R4 full", rts_n_o, 1);
      wr(11'h240);
      check("R4 bit6 ignored when full", rts_n_o, 1);
      rx_level_i = LW'(DEPTH - 1); tick(1);
      check("R4 one free", rts_n_o, 0);
      rx_level_i = '0;
      wr(11'h000);
   endtask

   task automatic t_enable;
      tx_busy_i = 1'b1; rx_busy_i = 1'b1;
      wr(11'h007); tick(2);
      check("R7 hold off while busy", {tx_run_o, rx_run_o}, 0);
      tx_busy_i = 1'b0; rx_busy_i = 1'b0; tick(2);
      check("R7 run after idle", {tx_run_o, rx_run_o}, 2'b11);
      tx_req_i = 1'b1; tick(1);
      check("R6 start", tx_start_o, 1);
      tx_busy_i = 1'b1; tick(1);
      check("R6 no start when busy", tx_start_o, 0);
      wr(11'h006); tick(2);
      check("R7 finish character", tx_run_o, 1);
      check("R7 rx stops when idle", rx_run_o, 0);
      tx_busy_i = 1'b0; tick(2);
      check("R7 stopped", tx_run_o, 0);
      check("R6 no start when stopped", tx_start_o, 0);
      wr(11'h005); tick(2);
      check("R7 tx enable off", {tx_run_o, rx_run_o}, 2'b01);
      tx_req_i = 1'b0;
      wr(11'h000); tick(2);
   endtask

   task automatic t_cts;
      tx_req_i = 1'b1; cts_n_i = 1'b1;
      wr(11'h403); tick(3);
      check("R5 blocked by cts high", tx_start_o, 0);
      cts_n_i = 1'b0; tick(1);
      check("R5 sync latency", tx_start_o, 0);
      tick(3);
      check("R5 allowed after cts low", tx_start_o, 1);
      cts_n_i = 1'b1;
      wr(11'h003); tick(3);
      check("R5 cts ignored when flow off", tx_start_o, 1);
      tx_req_i = 1'b0;
      wr(11'h000); tick(2);
   endtask

   task automatic t_loop;
      ir_test_i = 1'b0; rxd_i = 1'b1;
      wr(11'h009);
      txd_core_i = 1'b0; tick(1);
      check("R8 loop txd 0", rxd_core_o, 0);
      txd_core_i = 1'b1; rxd_i = 1'b0; tick(1);
      check("R8 loop txd 1, pin ignored", rxd_core_o, 1);
      dcd_n_i = 1'b0; cts_n_i = 1'b0; ri_n_i = 1'b0;
      wr(11'h069);
      check("R10 cts<-rts dsr<-dtr", {cts_n_core_o, dsr_n_core_o}, 2'b00);
      check("R10 dcd<-out1 ri<-out2", {dcd_n_core_o, ri_n_core_o}, 2'b11);
      wr(11'h000);
      check("R10 pins when loop off", {cts_n_core_o, dcd_n_core_o, ri_n_core_o}, 3'b000);
      check("R8 pin when loop off", rxd_core_o, 0);
      dcd_n_i = 1'b1; cts_n_i = 1'b1; ri_n_i = 1'b1; rxd_i = 1'b1;
   endtask

   task automatic t_ir;
      ir_test_i = 1'b1;
      wr(11'h019);
      ir_out_core_i = 1'b0; tick(1);
      check("R9 inverted loop 0", ir_in_core_o, 1);
      ir_out_core_i = 1'b1; tick(1);
      check("R9 inverted loop 1", ir_in_core_o, 0);
      ir_test_i = 1'b0;
      wr(11'h011);
      txd_core_i = 1'b0; rxd_i = 1'b0; ir_in_i = 1'b1; ir_out_core_i = 1'b1; tick(1);
      check("R11 txd held high", txd_o, 1);
      check("R11 rxd ignored", rxd_core_o, 1);
      check("R11 ir paths", {ir_in_core_o, ir_out_n_o}, 2'b11);
      wr(11'h001);
      check("R11 ir off out low", ir_out_n_o, 0);
      check("R11 ir off in ignored", ir_in_core_o, 0);
      check("R11 txd follows core", txd_o, 0);
      txd_core_i = 1'b1; rxd_i = 1'b1;
      wr(11'h000);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_regs();
      t_rts();
      t_enable();
      t_cts();
      t_loop();
      t_ir();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule